// File: doc/BRIEF.md
# Clock Frequency Watchdog with Timed Reset Pulse

This block guards a programmable clock generator against a frequency setting that leaves the system hung. Software arms it by setting a run bit, and from then on it counts down a programmed number of time units, each unit built from a fixed number of base ticks (290 one-millisecond ticks in the default build). Software proves the system is alive by rewriting the timeout count, which starts the countdown afresh.

If the countdown runs out, the block latches an alarm, switches the frequency code it drives from the normal code to a stored safe code, and pulls an open-drain, active-low system reset line low for a fixed number of ticks (32 by default). The alarm stays set until software clears it, so a single failure produces exactly one reset pulse. Clearing the alarm gives the normal code back to the clock logic and, if the run bit is still set, starts a fresh countdown.

The base tick is an input pulse one clock wide, so the unit and pulse lengths are counts of ticks and a bench can shrink them through parameters.

Top module: `clk_watchdog`

## Requirements
- R1: After reset the alarm is 0, the reset line is released (`rst_od_n` = 1), `fs_sel` equals `fs_normal`, the run bit is 0, the safe code is 0 and the timeout count is 16 (0x10).
- R2: With the run bit at 0 no amount of ticks raises the alarm or pulls the reset line.
- R3: Once started, the alarm rises in the cycle after the tick that completes count × UNIT_TICKS ticks; the cycle of the starting write does not count. A count of 0 behaves as 1.
- R4: While the alarm is 1, `fs_sel` carries the safe code last written with the control write; while it is 0, `fs_sel` follows `fs_normal`.
- R5: On expiry `rst_od_n` goes to 0 in the same cycle as the alarm and returns to 1 after PULSE_TICKS further ticks; the block only ever drives it to 0 or releases it.
- R6: A count write (`cnt_we`) stores the new count and, if running, restarts the countdown from it, so periodic count writes keep the alarm from rising.
- R7: While the alarm is 1 the countdown is frozen: no second expiry and no second reset pulse occur.
- R8: `alarm_clr` sets the alarm to 0 in the next cycle, returns `fs_sel` to `fs_normal`, and restarts a full countdown if the run bit is 1.
- R9: A control write with `ctl_run` = 0 stops the countdown; a later control write with `ctl_run` = 1 restarts a full period.
- R10: Time advances only on cycles with `tick` = 1; clock cycles without a tick do not bring expiry nearer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle base time pulse |
| ctl_we | input | 1 | Control write strobe (run bit and safe code) |
| ctl_run | input | 1 | Run bit value: 1 start, 0 stop |
| ctl_safe | input | FS_W | Safe frequency code value |
| cnt_we | input | 1 | Timeout count write strobe (also the kick) |
| cnt_val | input | CNT_W | Timeout count in units |
| alarm_clr | input | 1 | Clears the alarm status |
| fs_normal | input | FS_W | Frequency code used when no alarm |
| fs_sel | output | FS_W | Frequency code driven to the clock logic |
| alarm | output | 1 | Alarm status: 1 alarm, 0 normal |
| rst_od_n | output | 1 | Open-drain reset: 0 pull low, 1 released |

## Verification
The assertions watch, on every cycle, the relations that need no long memory: the alarm is sticky until cleared and falls right after a clear, the reset line only falls together with a rising alarm, an alarm only rises on a tick cycle, the selected code is frozen while the alarm holds, and the low time of the reset line never exceeds the pulse length. The exact timeout length for a given count, the zero-count case, the effect of kicks, stopping and restarting, and idle cycles without ticks can only be shown by the bench's scenarios, which measure cycle counts against values computed from the parameters and compare every output each cycle with a bench model under random traffic.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    // Reason the countdown is reloaded in a given cycle.
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_CLEAR = 2'd1,
        LD_KICK  = 2'd2,
        LD_START = 2'd3
    } cwd_load_e;

endpackage

// File: rtl/cwd_prescale.sv
// Divides base ticks into time units; unit_done pulses on the tick closing a unit.
module cwd_prescale #(
    parameter int UNIT_TICKS = 290
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic enable,
    output logic unit_done
);
    localparam int SW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [SW-1:0] LAST = SW'(UNIT_TICKS - 1);

    logic [SW-1:0] sub_d, sub_q;

    always_comb begin
        sub_d     = sub_q;
        unit_done = 1'b0;
        if (clear) begin
            sub_d = '0;
        end else if (tick && enable) begin
            if (sub_q == LAST) begin
                sub_d     = '0;
                unit_done = 1'b1;
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/cwd_pulse.sv
// Holds the reset request low for PULSE_TICKS ticks after fire.
module cwd_pulse #(
    parameter int PULSE_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fire,
    output logic low
);
    localparam int LW = $clog2(PULSE_TICKS + 1);
    localparam logic [LW-1:0] WIDTH = LW'(PULSE_TICKS);

    logic [LW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire)                       left_d = WIDTH;
        else if (tick && left_q != '0)  left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign low = (left_q != '0);
endmodule

// File: rtl/clk_watchdog.sv
module clk_watchdog
    import cwd_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int FS_W        = 4,
    parameter int UNIT_TICKS  = 290,
    parameter int PULSE_TICKS = 32,
    parameter int CNT_RST     = 16,
    parameter int SAFE_RST    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_we,
    input  logic             ctl_run,
    input  logic [FS_W-1:0]  ctl_safe,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             alarm_clr,
    input  logic [FS_W-1:0]  fs_normal,
    output logic [FS_W-1:0]  fs_sel,
    output logic             alarm,
    output logic             rst_od_n
);
    typedef struct packed {
        logic             run;
        logic             alarm;
        logic [FS_W-1:0]  safe;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] units;
    } wd_state_t;

    localparam wd_state_t ST_RST = '{
        run:   1'b0,
        alarm: 1'b0,
        safe:  FS_W'(SAFE_RST),
        cnt:   CNT_W'(CNT_RST),
        units: CNT_W'(CNT_RST)
    };

    wd_state_t st_d, st_q;
    cwd_load_e load;
    logic      restart;
    logic      unit_done;
    logic      expire;
    logic      pulse_low;

    always_comb begin
        st_d = st_q;

        load = LD_NONE;
        if (alarm_clr)          load = LD_CLEAR;
        if (cnt_we)             load = LD_KICK;
        if (ctl_we && ctl_run)  load = LD_START;
        restart = (load != LD_NONE) || ctl_we;

        if (ctl_we) begin
            st_d.run  = ctl_run;
            st_d.safe = ctl_safe;
        end
        if (cnt_we) st_d.cnt = cnt_val;

        // unit_done is suppressed by restart, so expiry and reload never coincide
        expire = unit_done && (st_q.units <= CNT_W'(1));

        if (load != LD_NONE)                    st_d.units = st_d.cnt;
        else if (unit_done && st_q.units != '0) st_d.units = st_q.units - 1'b1;

        if (expire)         st_d.alarm = 1'b1;
        else if (alarm_clr) st_d.alarm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    cwd_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clear     (restart),
        .enable    (st_q.run && !st_q.alarm),
        .unit_done (unit_done)
    );

    cwd_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (expire),
        .low   (pulse_low)
    );

    assign alarm    = st_q.alarm;
    assign fs_sel   = st_q.alarm ? st_q.safe : fs_normal;
    assign rst_od_n = !pulse_low;
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int FS_W        = 4,
    parameter int PULSE_TICKS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            ctl_we,
    input logic            alarm_clr,
    input logic [FS_W-1:0] fs_sel,
    input logic            alarm,
    input logic            rst_od_n
);
    int low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_ticks <= 0;
        else if (rst_od_n)       low_ticks <= 0;
        else if (tick)           low_ticks <= low_ticks + 1;
    end

    a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !alarm_clr) |=> alarm);

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_clr |=> !alarm);

    a_r5_low_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> !rst_od_n);

    a_r5_fall_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_od_n) |-> $rose(alarm));

    a_r10_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(tick));

    a_r4_safe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && $past(alarm) && !$past(ctl_we)) |-> $stable(fs_sel));

    a_r5_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= PULSE_TICKS);
endmodule

bind clk_watchdog cwd_checker #(
    .FS_W        (FS_W),
    .PULSE_TICKS (PULSE_TICKS)
) u_cwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctl_we    (ctl_we),
    .alarm_clr (alarm_clr),
    .fs_sel    (fs_sel),
    .alarm     (alarm),
    .rst_od_n  (rst_od_n)
);

// File: tb/clk_watchdog_test.sv
`timescale 1ns/100ps
module clk_watchdog_test;
    localparam int CNT_W = 8;
    localparam int FS_W  = 4;
    localparam int UNIT  = 4;
    localparam int PULSE = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             ctl_we = 1'b0;
    logic             ctl_run = 1'b0;
    logic [FS_W-1:0]  ctl_safe = '0;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             alarm_clr = 1'b0;
    logic [FS_W-1:0]  fs_normal = 4'h3;
    logic [FS_W-1:0]  fs_sel;
    logic             alarm;
    logic             rst_od_n;

    always #2.5 clk = ~clk;

    clk_watchdog #(
        .CNT_W(CNT_W), .FS_W(FS_W), .UNIT_TICKS(UNIT), .PULSE_TICKS(PULSE),
        .CNT_RST(16), .SAFE_RST(0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we), .ctl_run(ctl_run),
        .ctl_safe(ctl_safe), .cnt_we(cnt_we), .cnt_val(cnt_val), .alarm_clr(alarm_clr),
        .fs_normal(fs_normal), .fs_sel(fs_sel), .alarm(alarm), .rst_od_n(rst_od_n)
    );

    int total = 0;
    int bad = 0;
    bit checking = 1'b0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Bench model: elapsed ticks against count*UNIT
    bit               m_run, m_alarm;
    logic [FS_W-1:0]  m_safe;
    logic [CNT_W-1:0] m_cnt;
    int               m_el, m_plow;

    function automatic int limit_of(logic [CNT_W-1:0] c);
        return ((c == 0) ? 1 : int'(c)) * UNIT;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 0; m_alarm <= 0; m_safe <= '0; m_cnt <= 8'd16; m_el <= 0; m_plow <= 0;
        end else begin
            bit reload, exp_now;
            reload  = ctl_we || cnt_we || alarm_clr;
            exp_now = !reload && tick && m_run && !m_alarm && (m_el + 1 == limit_of(m_cnt));
            if (ctl_we) begin m_run <= ctl_run; m_safe <= ctl_safe; end
            if (cnt_we) m_cnt <= cnt_val;
            if (reload) m_el <= 0;
            else if (tick && m_run && !m_alarm) m_el <= m_el + 1;
            if (exp_now) m_alarm <= 1;
            else if (alarm_clr) m_alarm <= 0;
            if (exp_now) m_plow <= PULSE;
            else if (tick && m_plow > 0) m_plow <= m_plow - 1;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            check("R3", "alarm", 32'(alarm), 32'(m_alarm));
            check("R4", "fs_sel", 32'(fs_sel), 32'(m_alarm ? m_safe : fs_normal));
            check("R5", "rst_od_n", 32'(rst_od_n), 32'(m_plow == 0));
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr_ctl(bit run, logic [FS_W-1:0] safe);
        cyc(); ctl_we = 1; ctl_run = run; ctl_safe = safe;
        cyc(); ctl_we = 0;
    endtask

    task automatic kick(logic [CNT_W-1:0] v);
        cyc(); cnt_we = 1; cnt_val = v;
        cyc(); cnt_we = 0;
    endtask

    task automatic clear_alarm();
        cyc(); alarm_clr = 1;
        cyc(); alarm_clr = 0;
    endtask

    task automatic wait_alarm(int lim, output int k);
        k = 0;
        while (!alarm && k < lim) begin cyc(); k++; end
    endtask

    task automatic low_len(output int n);
        n = 0;
        while (!rst_od_n && n < 1000) begin n++; cyc(); end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k, n, lows;
        void'($urandom(32'd4242));
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check("R1", "alarm", 32'(alarm), 0);
        check("R1", "rst_od_n", 32'(rst_od_n), 1);
        check("R1", "fs_sel", 32'(fs_sel), 32'(fs_normal));
        checking = 1;

        // R2: ticks without run do nothing
        tick = 1;
        repeat (100) cyc();
        check("R2", "alarm idle", 32'(alarm), 0);
        check("R2", "rst idle", 32'(rst_od_n), 1);

        // R1/R3: default count 16 -> 64 ticks; R4 safe code; R5 width
        wr_ctl(1, 4'hA);
        wait_alarm(1000, k);
        check("R1", "default timeout ticks", 32'(k), 16 * UNIT);
        check("R4", "safe code", 32'(fs_sel), 32'hA);
        check("R5", "low at alarm", 32'(rst_od_n), 0);
        low_len(n);
        check("R5", "pulse width", 32'(n), PULSE);

        // R7: no second pulse while alarm held
        lows = 0;
        for (int i = 0; i < 60; i++) begin cyc(); if (!rst_od_n) lows++; end
        check("R7", "extra low cycles", 32'(lows), 0);
        check("R7", "alarm held", 32'(alarm), 1);

        // R8: clear restores normal code and restarts
        clear_alarm();
        check("R8", "alarm cleared", 32'(alarm), 0);
        check("R8", "fs restored", 32'(fs_sel), 32'(fs_normal));
        wait_alarm(1000, k);
        check("R8", "restart ticks", 32'(k), 16 * UNIT);

        // R6: kicks hold off the alarm
        clear_alarm();
        for (int i = 0; i < 5; i++) begin kick(8'd2); repeat (6) cyc(); end
        check("R6", "no alarm while kicked", 32'(alarm), 0);
        kick(8'd2);
        wait_alarm(1000, k);
        check("R6", "timeout after last kick", 32'(k), 2 * UNIT);

        // R3: count 0 acts as 1
        clear_alarm();
        kick(8'd0);
        wait_alarm(1000, k);
        check("R3", "zero count ticks", 32'(k), UNIT);

        // R9: stop and restart
        clear_alarm();
        kick(8'd3);
        repeat (5) cyc();
        wr_ctl(0, 4'hA);
        repeat (50) cyc();
        check("R9", "no alarm when stopped", 32'(alarm), 0);
        wr_ctl(1, 4'hC);
        wait_alarm(1000, k);
        check("R9", "full period after restart", 32'(k), 3 * UNIT);
        check("R4", "new safe code", 32'(fs_sel), 32'hC);

        // R10: no ticks, no progress
        clear_alarm();
        tick = 0;
        kick(8'd1);
        repeat (100) cyc();
        check("R10", "no alarm without ticks", 32'(alarm), 0);
        cyc(); tick = 1;
        wait_alarm(1000, k);
        check("R10", "ticks to expiry", 32'(k), UNIT);

        // Random traffic against the model
        clear_alarm();
        for (int i = 0; i < 4000; i++) begin
            cyc();
            tick      = ($urandom % 2) == 0;
            fs_normal = FS_W'($urandom);
            cnt_we    = ($urandom % 30) == 0;
            cnt_val   = CNT_W'($urandom % 5);
            ctl_we    = ($urandom % 60) == 0;
            ctl_run   = ($urandom % 4) != 0;
            ctl_safe  = FS_W'($urandom);
            alarm_clr = ($urandom % 40) == 0;
        end
        cyc();
        tick = 0; cnt_we = 0; ctl_we = 0; alarm_clr = 0;
        repeat (3) cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule